// File: doc/BRIEF.md
# Cache Block Refill Sequencer

After a cache miss, this controller fetches one 16-word block from main memory and hands the words to the cache. Each request carries a block address and a memory organisation code. The code is chosen separately for every request. The sequencer drives the block address to memory for one cycle. It then runs a fixed number of access rounds, each lasting a fixed access latency. After every access it transfers the words it read and presents them to the cache. Each delivered word has a valid strobe, a word index within the block, and its data.

Three memory organisations are supported:

- **Single-word:** memory and bus are both one word wide. Each round reads and moves one word.
- **Quad:** memory and bus are both four words wide. Each round reads four words and moves them in one bus cycle on four output lanes.
- **Banked:** four one-word banks are read in parallel. Their four words then cross a one-word bus in four consecutive cycles.

The state machine has four states:

- `ST_IDLE`: waits for `req`, latches the code and the block address, and moves to `ST_ADDR`.
- `ST_ADDR`: lasts one cycle, then moves to `ST_ACCESS` and loads the latency timer.
- `ST_ACCESS`: moves to `ST_XFER` when the timer expires.
- `ST_XFER`: stays here for every beat except the last beat of a round. At the end of a round it returns to `ST_ACCESS` (reloading the timer) if words remain. Otherwise it returns to `ST_IDLE` and raises `done`.

Top module: `blk_refill_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, `busy`, `done`, `mem_addr_vld` and every `fill_vld` lane are low.
- R2: When `req` is high in an idle cycle, the request is accepted at that edge and `busy` rises. In the next cycle, and only in that cycle, `mem_addr_vld` is high with `mem_blk` equal to the requested block.
- R3: With `req_mode` = 2'b00 (single-word), 16 strobes each carry one word on lane 0. `done` falls in the 177th busy cycle (1 + 16×10 + 16×1).
- R4: With `req_mode` = 2'b01 (quad), 4 strobes each assert all four lanes together. `done` falls in the 45th busy cycle (1 + 4×10 + 4×1).
- R5: With `req_mode` = 2'b10 (banked), 16 single-lane strobes arrive in groups of four consecutive cycles. `done` falls in the 57th busy cycle (1 + 4×10 + 16×1).
- R6: Words are delivered in ascending index order starting at 0. Lane l carries index base+l, where base is the value of `mem_idx`. Each lane's data equals the `mem_rdata` lane l presented during that strobe cycle.
- R7: `done` is high for exactly one cycle, in the same cycle as the final strobe. In the following cycle `busy` is low.
- R8: While busy, `req`, `req_mode` and `req_blk` are ignored. Changing them mid-refill alters neither the timing nor the block fetched.
- R9: `req_mode` = 2'b11 is handled as single-word: 16 one-word strobes, with `done` in busy cycle 177.
- R10: A new request raised in the first idle cycle after `done` is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Refill request |
| req_mode | input | 2 | Memory organisation code |
| req_blk | input | BAW | Block address |
| busy | output | 1 | Refill in progress |
| mem_addr_vld | output | 1 | Address-send cycle to memory |
| mem_blk | output | BAW | Latched block address for memory |
| mem_idx | output | IDXW | Index of the first word on the current transfer |
| mem_rdata | input | LANES×DW | Memory read data; lane 0 is used for one-word transfers |
| fill_vld | output | LANES | Per-lane word strobe to the cache |
| fill_idx | output | LANES×IDXW | Per-lane word index |
| fill_data | output | LANES×DW | Per-lane word data |
| done | output | 1 | Block complete; coincides with the final strobe |

## Verification
The bench counts busy cycles from the accepting edge. Count 1 is the address cycle, and `done` must appear exactly at count 177, 45 or 57 depending on the organisation. The first strobe is due at count 12, after the address cycle and ten access cycles. Every output is sampled 1 ns after each rising edge, so the register updates of that edge are already visible. The bench checks that `busy` is low in the cycle after `done`. It also checks that a request raised at the following falling edge is accepted at the next rising edge.

// File: rtl/refill_pkg.sv
package refill_pkg;
    typedef enum logic [1:0] {
        MODE_NARROW = 2'b00,
        MODE_WIDE   = 2'b01,
        MODE_ILV    = 2'b10,
        MODE_RSVD   = 2'b11
    } org_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_XFER
    } st_e;
endpackage

// File: rtl/refill_timer.sv
module refill_timer #(
    parameter int LAT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(LAT - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    generate
        if (LAT > 1) begin : g_chk
            // R3: an access never finishes in the cycle right after it starts
            p_no_early_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> !expired);
        end
    endgenerate
endmodule

// File: rtl/refill_lanes.sv
module refill_lanes #(
    parameter int DW    = 32,
    parameter int IDXW  = 4,
    parameter int LANES = 4
) (
    input  logic                  en,
    input  logic                  wide,
    input  logic [IDXW-1:0]       base_idx,
    input  logic [LANES*DW-1:0]   mem_rdata,
    output logic [LANES-1:0]      fill_vld,
    output logic [LANES*IDXW-1:0] fill_idx,
    output logic [LANES*DW-1:0]   fill_data
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic lane_on;
            if (l == 0) begin : g_first
                assign lane_on = en;
            end else begin : g_rest
                assign lane_on = en && wide;
            end
            assign fill_vld[l]                 = lane_on;
            assign fill_idx[l*IDXW +: IDXW]    = base_idx + IDXW'(l);
            assign fill_data[l*DW +: DW]       = lane_on ? mem_rdata[l*DW +: DW] : '0;
        end
    endgenerate
endmodule

// File: rtl/blk_refill_seq.sv
module blk_refill_seq
    import refill_pkg::*;
#(
    parameter int DW      = 32,
    parameter int BAW     = 26,
    parameter int WORDS   = 16,
    parameter int LANES   = 4,
    parameter int ACC_LAT = 10,
    localparam int IDXW   = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [1:0]            req_mode,
    input  logic [BAW-1:0]        req_blk,
    output logic                  busy,
    output logic                  mem_addr_vld,
    output logic [BAW-1:0]        mem_blk,
    output logic [IDXW-1:0]       mem_idx,
    input  logic [LANES*DW-1:0]   mem_rdata,
    output logic [LANES-1:0]      fill_vld,
    output logic [LANES*IDXW-1:0] fill_idx,
    output logic [LANES*DW-1:0]   fill_data,
    output logic                  done
);
    localparam logic [IDXW-1:0] LANE_MASK = IDXW'(LANES - 1);
    localparam logic [IDXW-1:0] LAST_ONE  = IDXW'(WORDS - 1);
    localparam logic [IDXW-1:0] LAST_QUAD = IDXW'(WORDS - LANES);

    st_e             st_q, st_d;
    org_e            mode_q;
    logic [BAW-1:0]  blk_q;
    logic [IDXW-1:0] ptr_q;
    logic            acc_done, tmr_load, round_end, ptr_last, xfer;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // request latch and word pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NARROW;
            blk_q  <= '0;
            ptr_q  <= '0;
        end else if (st_q == ST_IDLE && req) begin
            mode_q <= (org_e'(req_mode) == MODE_RSVD) ? MODE_NARROW : org_e'(req_mode);
            blk_q  <= req_blk;
            ptr_q  <= '0;
        end else if (xfer) begin
            ptr_q  <= ptr_q + ((mode_q == MODE_WIDE) ? IDXW'(LANES) : IDXW'(1));
        end
    end

    assign round_end = (mode_q != MODE_ILV) || ((ptr_q & LANE_MASK) == LANE_MASK);
    assign ptr_last  = (mode_q == MODE_WIDE) ? (ptr_q == LAST_QUAD) : (ptr_q == LAST_ONE);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req) st_d = ST_ADDR;
            ST_ADDR:   st_d = ST_ACCESS;
            ST_ACCESS: if (acc_done) st_d = ST_XFER;
            ST_XFER:   if (round_end) st_d = ptr_last ? ST_IDLE : ST_ACCESS;
            default:   st_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (st_q != ST_ACCESS) && (st_d == ST_ACCESS);

    // outputs
    always_comb begin
        busy         = 1'b0;
        mem_addr_vld = 1'b0;
        xfer         = 1'b0;
        done         = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_ADDR:   begin busy = 1'b1; mem_addr_vld = 1'b1; end
            ST_ACCESS: busy = 1'b1;
            ST_XFER:   begin busy = 1'b1; xfer = 1'b1; done = round_end && ptr_last; end
            default:   ;
        endcase
    end

    assign mem_blk = blk_q;
    assign mem_idx = ptr_q;

    refill_timer #(.LAT(ACC_LAT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (acc_done)
    );

    refill_lanes #(.DW(DW), .IDXW(IDXW), .LANES(LANES)) u_lanes (
        .en        (xfer),
        .wide      (mode_q == MODE_WIDE),
        .base_idx  (ptr_q),
        .mem_rdata (mem_rdata),
        .fill_vld  (fill_vld),
        .fill_idx  (fill_idx),
        .fill_data (fill_data)
    );

    // assertions
    p_addr_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> (mem_addr_vld && busy));
    p_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld[0] && mode_q != MODE_WIDE) |-> (fill_vld == LANES'(1)));
    p_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld[0] && mode_q == MODE_WIDE) |-> (&fill_vld));
    p_done_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fill_vld[0]);
    p_done_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_hold_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && st_d != ST_IDLE) |=> ($stable(mode_q) && $stable(blk_q)));
    p_rsvd_as_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mode_q != MODE_RSVD));
endmodule

// File: tb/blk_refill_seq_bench.sv
module blk_refill_seq_bench;
    localparam int DW = 32, BAW = 26, WORDS = 16, LANES = 4, IDXW = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req = 1'b0;
    logic [1:0]            req_mode = 2'b00;
    logic [BAW-1:0]        req_blk = '0;
    logic                  busy, mem_addr_vld, done;
    logic [BAW-1:0]        mem_blk;
    logic [IDXW-1:0]       mem_idx;
    logic [LANES*DW-1:0]   mem_rdata;
    logic [LANES-1:0]      fill_vld;
    logic [LANES*IDXW-1:0] fill_idx;
    logic [LANES*DW-1:0]   fill_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    blk_refill_seq u_blk_refill_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_mode(req_mode), .req_blk(req_blk),
        .busy(busy), .mem_addr_vld(mem_addr_vld), .mem_blk(mem_blk), .mem_idx(mem_idx),
        .mem_rdata(mem_rdata), .fill_vld(fill_vld), .fill_idx(fill_idx),
        .fill_data(fill_data), .done(done)
    );

    function automatic logic [DW-1:0] word_of(input logic [BAW-1:0] b, input logic [IDXW-1:0] i);
        return {b[19:0], 8'hC3, i};
    endfunction

    // memory model: lane l returns the word at mem_idx + l of the latched block
    always_comb begin
        for (int l = 0; l < LANES; l++)
            mem_rdata[l*DW +: DW] = word_of(mem_blk, mem_idx + IDXW'(l));
    end

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run_refill(input logic [1:0] m, input logic [BAW-1:0] b, input int exp_n,
                              input int exp_strobes, input bit disturb, input string rq);
        int n, words, strobes, prev;
        logic [IDXW-1:0] expi;
        bit fin;
        @(negedge clk);
        req = 1'b1; req_mode = m; req_blk = b;
        @(posedge clk); #1;
        check(busy === 1'b1, "R2/R10 accept", longint'(busy), 1);
        if (disturb) begin
            req_mode = ~m; req_blk = ~b;   // R8: changes while busy
        end else begin
            req = 1'b0;
        end
        n = 1; words = 0; strobes = 0; prev = -100; expi = '0; fin = 1'b0;
        check(mem_addr_vld === 1'b1 && mem_blk === b, "R2 addr", longint'(mem_blk), longint'(b));
        while (!fin && n < 400) begin
            if (n == 2) check(mem_addr_vld === 1'b0, "R2 single addr cycle", longint'(mem_addr_vld), 0);
            if (fill_vld[0]) begin
                strobes++;
                if (m == 2'b01) check(fill_vld === 4'hF, {rq, " lanes"}, longint'(fill_vld), 4'hF);
                else            check(fill_vld === 4'h1, {rq, " lanes"}, longint'(fill_vld), 4'h1);
                if (m == 2'b10 && (expi % 4) != 0)
                    check(n == prev + 1, "R5 consecutive", n, prev + 1);
                prev = n;
            end
            for (int l = 0; l < LANES; l++) begin
                if (fill_vld[l]) begin
                    check(fill_idx[l*IDXW +: IDXW] === expi, "R6 index",
                          longint'(fill_idx[l*IDXW +: IDXW]), longint'(expi));
                    check(fill_data[l*DW +: DW] === word_of(b, expi), "R6/R8 data",
                          longint'(fill_data[l*DW +: DW]), longint'(word_of(b, expi)));
                    expi = expi + 1'b1;
                    words++;
                end
            end
            if (done === 1'b1) begin
                check(fill_vld[0] === 1'b1, "R7 done with strobe", longint'(fill_vld), 1);
                fin = 1'b1;
            end else begin
                if (disturb && n == 100) req = 1'b0;
                @(posedge clk); #1;
                n++;
            end
        end
        check(fin, {rq, " done seen"}, longint'(fin), 1);
        check(n == exp_n, {rq, " cycle count"}, n, exp_n);
        check(words == WORDS, {rq, " word count"}, words, WORDS);
        check(strobes == exp_strobes, {rq, " strobe count"}, strobes, exp_strobes);
        @(posedge clk); #1;
        check(done === 1'b0 && busy === 1'b0, "R7 idle after done", longint'({done, busy}), 0);
    endtask

    task automatic test_reset;
        check(busy === 1'b0 && done === 1'b0 && mem_addr_vld === 1'b0 && fill_vld === '0,
              "R1 in reset", longint'({busy, done, mem_addr_vld, fill_vld}), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(busy === 1'b0 && done === 1'b0 && mem_addr_vld === 1'b0 && fill_vld === '0,
              "R1 idle", longint'({busy, done, mem_addr_vld, fill_vld}), 0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        test_reset();
        run_refill(2'b00, 26'h0123456, 177, 16, 1'b0, "R3 single-word");
        run_refill(2'b01, 26'h2ABCDEF, 45, 4, 1'b0, "R4 quad");
        run_refill(2'b10, 26'h1000F0F, 57, 16, 1'b0, "R5 banked");
        run_refill(2'b11, 26'h0777777, 177, 16, 1'b0, "R9 reserved code");
        run_refill(2'b10, 26'h0055AA0, 57, 16, 1'b1, "R8 ignored while busy");
        // R10: back-to-back requests with no gap
        run_refill(2'b01, 26'h3000001, 45, 4, 1'b0, "R10 back-to-back quad");
        run_refill(2'b00, 26'h3000002, 177, 16, 1'b0, "R10 back-to-back single");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule